// File: doc/BRIEF.md
# Serial Receive Queue with Per-Byte Error Status

This block sits between a serial receiver's deserializer and the host side of a serial port. Each time the deserializer finishes a frame, it presents the eight data bits, a parity-check result and the sample of the first stop bit. The queue classifies that frame as clean, framing-errored or a line break. It then stores the byte together with its error flags, so the host reads every flag in the same cycle as the byte it belongs to.

The host sees the oldest stored entry, the number of stored entries, and empty and full indications, and pops one entry per read strobe. A line break is stored as two zero bytes. A frame that finds no room is dropped, and that loss is marked on the most recently stored entry, so the host learns where in the byte stream data went missing.

Top module: `uart_rx_status_fifo`

## Requirements
- R1: The queue holds DEPTH (default 16) entries of 12 bits, read out in arrival order on `head_entry`, with the fields data byte [7:0], parity error [8], framing error [9], break [10] and overrun [11].
- R2: A frame with a stop-bit sample of 1 stores its byte with framing and break flags 0 and the parity flag equal to `frame_par_err`, one cycle after the strobe.
- R3: A frame with a stop-bit sample of 0 and a nonzero byte stores that byte with the framing flag 1 and the break flag 0.
- R4: A frame with a stop-bit sample of 0 and an all-zero byte is a break: two entries of data 0x00 are stored in one cycle, each with framing and break flags 1 and the parity flag copied from the frame.
- R5: A frame arriving while the queue holds DEPTH entries and no read is made is dropped. The stored bytes stay unchanged, the overrun flag [11] is set on the most recently stored entry, and the count stays DEPTH.
- R6: A break arriving with exactly one free entry stores the first 0x00 entry in that entry and marks it with the overrun flag. The second entry is dropped.
- R7: A read and a frame in the same cycle are both served and leave the count unchanged, including when the queue is full, where no overrun is flagged.
- R8: While the queue is empty, `head_entry` reads 0 and a read strobe has no effect on the count or the head.
- R9: `fill_count` equals the number of stored entries, `empty` is high exactly at count 0 and `full` exactly at count DEPTH. Reset empties the queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_vld | input | 1 | One-cycle strobe: a frame was received |
| frame_data | input | 8 | Received data bits |
| frame_par_err | input | 1 | Parity check failed for this frame |
| frame_stop_bit | input | 1 | Sample of the first stop bit |
| rd_en | input | 1 | Host pops the head entry |
| head_entry | output | 12 | Oldest entry: {overrun, break, framing, parity, data} |
| fill_count | output | 5 | Number of stored entries |
| empty | output | 1 | No entries stored |
| full | output | 1 | DEPTH entries stored |

## Verification
On every cycle the assertions check that the count moves by at most the amount one read and one break can cause, and that a read on an empty queue leaves it empty. They also check that the head is zero while empty, that a full queue stays full across a dropped frame or a concurrent read and write, and that a break into an empty queue yields a count of two. Only the bench scenarios can show that the flags travel with the right byte, that overrun lands on the newest entry and not on an older one, and that the bytes read after an overrun match what was written before it.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int BYTE_W  = 8;
  localparam int ENTRY_W = BYTE_W + 4;
  localparam int OVR_POS = BYTE_W + 3;

  typedef struct packed {
    logic              ovr;
    logic              brk;
    logic              frm;
    logic              par;
    logic [BYTE_W-1:0] data;
  } rxq_entry_t;
endpackage

// File: rtl/rxq_rst_sync.sv
module rxq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_core_n <= stage_q;
    end
  end
endmodule

// File: rtl/rxq_classify.sv
module rxq_classify
  import rxq_pkg::*;
(
  input  logic              frame_vld,
  input  logic [BYTE_W-1:0] frame_data,
  input  logic              frame_par_err,
  input  logic              frame_stop_bit,
  output logic [1:0]        push_n,
  output rxq_entry_t        ent_a,
  output rxq_entry_t        ent_b
);
  logic frm_err;
  logic brk_det;

  always_comb begin
    frm_err = ~frame_stop_bit;
    brk_det = frm_err && (frame_data == '0);

    ent_a.ovr  = 1'b0;
    ent_a.brk  = brk_det;
    ent_a.frm  = frm_err;
    ent_a.par  = frame_par_err;
    ent_a.data = brk_det ? '0 : frame_data;

    ent_b.ovr  = 1'b0;
    ent_b.brk  = 1'b1;
    ent_b.frm  = 1'b1;
    ent_b.par  = frame_par_err;
    ent_b.data = '0;

    if (!frame_vld)   push_n = 2'd0;
    else if (brk_det) push_n = 2'd2;
    else              push_n = 2'd1;
  end
endmodule

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_core_n,
  input  logic [1:0]                 push_n,
  input  rxq_entry_t                 ent_a,
  input  rxq_entry_t                 ent_b,
  input  logic                       pop,
  output logic [ENTRY_W-1:0]         head,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       empty,
  output logic                       full
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int AV_W  = CNT_W + 1;

  logic [PTR_W-1:0]   wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0]   rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [AV_W-1:0]    room;
  logic               rd_acc;
  logic [1:0]         acc;
  logic               ovr_evt;
  logic [PTR_W-1:0]   slot_b;
  logic [PTR_W-1:0]   tail_idx;

  logic [ENTRY_W-1:0] slot_q  [DEPTH];
  logic [ENTRY_W-1:0] slot_nx [DEPTH];
  logic [DEPTH-1:0]   slot_en;

  // Admission: a read in the same cycle frees one slot before writes land
  always_comb begin
    rd_acc = pop && (cnt_q != '0);
    room   = AV_W'(DEPTH) - AV_W'(cnt_q) + AV_W'(rd_acc);
    if (AV_W'(push_n) <= room) acc = push_n;
    else                       acc = room[1:0];
    ovr_evt  = (push_n > acc);
    slot_b   = wr_ptr_q + PTR_W'(1);
    tail_idx = wr_ptr_q + PTR_W'(acc) - PTR_W'(1);

    wr_ptr_d = wr_ptr_q + PTR_W'(acc);
    rd_ptr_d = rd_ptr_q + PTR_W'(rd_acc);
    cnt_d    = cnt_q + CNT_W'(acc) - CNT_W'(rd_acc);
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    logic wa, wb, mk;
    logic [ENTRY_W-1:0] base;
    assign wa = (acc != 2'd0) && (wr_ptr_q == PTR_W'(gi));
    assign wb = (acc == 2'd2) && (slot_b == PTR_W'(gi));
    assign mk = ovr_evt && (tail_idx == PTR_W'(gi));
    assign base = wa ? ENTRY_W'(ent_a) : (wb ? ENTRY_W'(ent_b) : slot_q[gi]);
    assign slot_nx[gi] = mk ? (base | (ENTRY_W'(1) << OVR_POS)) : base;
    assign slot_en[gi] = wa | wb | mk;
  end

  // Storage carries no reset: it is never visible while the queue is empty
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (slot_en[i]) slot_q[i] <= slot_nx[i];
    end
  end

  always_comb begin
    empty = (cnt_q == '0);
    full  = (cnt_q == CNT_W'(DEPTH));
    count = cnt_q;
    head  = empty ? '0 : slot_q[rd_ptr_q];
  end
endmodule

// File: rtl/uart_rx_status_fifo.sv
module uart_rx_status_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       frame_vld,
  input  logic [7:0]                 frame_data,
  input  logic                       frame_par_err,
  input  logic                       frame_stop_bit,
  input  logic                       rd_en,
  output logic [11:0]                head_entry,
  output logic [$clog2(DEPTH+1)-1:0] fill_count,
  output logic                       empty,
  output logic                       full
);
  logic       rst_core_n;
  logic [1:0] push_n;
  rxq_entry_t ent_a;
  rxq_entry_t ent_b;

  rxq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  rxq_classify u_cls (
    .frame_vld      (frame_vld),
    .frame_data     (frame_data),
    .frame_par_err  (frame_par_err),
    .frame_stop_bit (frame_stop_bit),
    .push_n         (push_n),
    .ent_a          (ent_a),
    .ent_b          (ent_b)
  );

  rxq_store #(.DEPTH(DEPTH)) u_store (
    .clk        (clk),
    .rst_core_n (rst_core_n),
    .push_n     (push_n),
    .ent_a      (ent_a),
    .ent_b      (ent_b),
    .pop        (rd_en),
    .head       (head_entry),
    .count      (fill_count),
    .empty      (empty),
    .full       (full)
  );
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
  parameter int DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst_core_n,
  input logic                       frame_vld,
  input logic [7:0]                 frame_data,
  input logic                       frame_stop_bit,
  input logic                       rd_en,
  input logic [11:0]                head_entry,
  input logic [$clog2(DEPTH+1)-1:0] fill_count,
  input logic                       empty,
  input logic                       full
);
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_core_n)
    1'b1 |=> (int'(fill_count) <= int'($past(fill_count)) + 2) &&
             (int'(fill_count) + 1 >= int'($past(fill_count)))); // R9

  AST_EMPTY_READ_IGNORED: assert property (@(posedge clk) disable iff (!rst_core_n)
    (empty && rd_en && !frame_vld) |=> empty); // R8

  AST_EMPTY_HEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_core_n)
    empty |-> (head_entry == 12'h000)); // R8

  AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_core_n)
    (full && !rd_en) |=> full); // R5

  AST_FULL_RW: assert property (@(posedge clk) disable iff (!rst_core_n)
    (full && rd_en && frame_vld && frame_stop_bit) |=> full); // R7

  AST_BREAK_TWO: assert property (@(posedge clk) disable iff (!rst_core_n)
    (empty && frame_vld && !frame_stop_bit && frame_data == 8'h00 && !rd_en)
      |=> (int'(fill_count) == 2)); // R4
endmodule

bind uart_rx_status_fifo rxq_checker #(.DEPTH(DEPTH)) u_rxq_chk (
  .clk            (clk),
  .rst_core_n     (rst_core_n),
  .frame_vld      (frame_vld),
  .frame_data     (frame_data),
  .frame_stop_bit (frame_stop_bit),
  .rd_en          (rd_en),
  .head_entry     (head_entry),
  .fill_count     (fill_count),
  .empty          (empty),
  .full           (full)
);

// File: tb/uart_rx_status_fifo_bench.sv
`timescale 1ns/1ps
module uart_rx_status_fifo_bench;
  localparam int DEPTH = 16;

  logic        clk;
  logic        rst_n;
  logic        frame_vld;
  logic [7:0]  frame_data;
  logic        frame_par_err;
  logic        frame_stop_bit;
  logic        rd_en;
  logic [11:0] head_entry;
  logic [4:0]  fill_count;
  logic        empty;
  logic        full;

  int n_chk  = 0;
  int n_fail = 0;

  uart_rx_status_fifo #(.DEPTH(DEPTH)) u_uart_rx_status_fifo (
    .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .frame_data(frame_data),
    .frame_par_err(frame_par_err), .frame_stop_bit(frame_stop_bit), .rd_en(rd_en),
    .head_entry(head_entry), .fill_count(fill_count), .empty(empty), .full(full)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // {vld, data, par, stop, rd, expected head, expected count}
  localparam int NVEC = 12;
  localparam logic [28:0] VEC [NVEC] = '{
    {1'b1, 8'h41, 1'b0, 1'b1, 1'b0, 12'h041, 5'd1},  // R2 clean byte
    {1'b1, 8'h42, 1'b1, 1'b1, 1'b0, 12'h041, 5'd2},  // R2 parity flag
    {1'b1, 8'h55, 1'b0, 1'b0, 1'b0, 12'h041, 5'd3},  // R3 framing
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 12'h142, 5'd2},  // R1 order, parity bit 8
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 12'h255, 5'd1},  // R3 framing bit 9
    {1'b1, 8'h00, 1'b1, 1'b0, 1'b1, 12'h700, 5'd2},  // R4 break with read
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 12'h700, 5'd1},  // R4 second zero entry
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 12'h000, 5'd0},  // R9 back to empty
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 12'h000, 5'd0},  // R8 read on empty
    {1'b1, 8'h00, 1'b0, 1'b1, 1'b0, 12'h000, 5'd1},  // R2 zero byte, not break
    {1'b1, 8'h7E, 1'b0, 1'b1, 1'b1, 12'h07E, 5'd1},  // R7 read and write
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 12'h000, 5'd0}   // R9 empty again
  };

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic step(input logic v, input logic [7:0] d, input logic p,
                      input logic s, input logic r);
    @(negedge clk);
    frame_vld = v; frame_data = d; frame_par_err = p; frame_stop_bit = s; rd_en = r;
    @(posedge clk);
    #2;
    frame_vld = 1'b0; frame_data = 8'h00; frame_par_err = 1'b0;
    frame_stop_bit = 1'b1; rd_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    #2;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    frame_vld = 1'b0; frame_data = 8'h00; frame_par_err = 1'b0;
    frame_stop_bit = 1'b1; rd_en = 1'b0;
    do_reset();
    check(32'(empty), 1, "R9 reset empty");
    check(32'(full), 0, "R9 reset not full");
    check(32'(fill_count), 0, "R9 reset count");
    check(32'(head_entry), 0, "R8 reset head zero");

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][28], VEC[i][27:20], VEC[i][19], VEC[i][18], VEC[i][17]);
      check(32'(head_entry), 32'(VEC[i][16:5]), $sformatf("R1 vector %0d head", i));
      check(32'(fill_count), 32'(VEC[i][4:0]), $sformatf("R9 vector %0d count", i));
    end

    // R5: overrun on full queue marks newest entry only
    for (int i = 0; i < DEPTH; i++) step(1'b1, 8'(i + 1), 1'b0, 1'b1, 1'b0);
    check(32'(full), 1, "R9 full flag");
    step(1'b1, 8'hAA, 1'b0, 1'b1, 1'b0);
    check(32'(fill_count), DEPTH, "R5 count held");
    for (int i = 0; i < DEPTH; i++) begin
      check(32'(head_entry), (i == DEPTH-1) ? 32'h810 : 32'(i + 1), "R5 drained entry");
      step(1'b0, 8'h00, 1'b0, 1'b1, 1'b1);
    end
    check(32'(empty), 1, "R5 drained empty");

    // R6: break with one free slot
    for (int i = 0; i < DEPTH-1; i++) step(1'b1, 8'(i + 1), 1'b0, 1'b1, 1'b0);
    step(1'b1, 8'h00, 1'b0, 1'b0, 1'b0);
    check(32'(fill_count), DEPTH, "R6 count after partial break");
    for (int i = 0; i < DEPTH; i++) begin
      check(32'(head_entry), (i == DEPTH-1) ? 32'hE00 : 32'(i + 1), "R6 drained entry");
      step(1'b0, 8'h00, 1'b0, 1'b1, 1'b1);
    end

    // R7: read and write together while full
    for (int i = 0; i < DEPTH; i++) step(1'b1, 8'(8'h21 + i), 1'b0, 1'b1, 1'b0);
    step(1'b1, 8'h99, 1'b0, 1'b1, 1'b1);
    check(32'(fill_count), DEPTH, "R7 full count unchanged");
    for (int i = 0; i < DEPTH; i++) begin
      check(32'(head_entry), (i == DEPTH-1) ? 32'h099 : 32'(8'h22 + i), "R7 drained entry");
      step(1'b0, 8'h00, 1'b0, 1'b1, 1'b1);
    end

    // R9: reset in the middle of traffic empties the queue
    step(1'b1, 8'h33, 1'b0, 1'b1, 1'b0);
    step(1'b1, 8'h34, 1'b0, 1'b1, 1'b0);
    do_reset();
    check(32'(fill_count), 0, "R9 mid-run reset count");
    check(32'(head_entry), 0, "R8 mid-run reset head");

    finish_run();
  end
endmodule